// File: doc/BRIEF.md
# Data Path Loopback Self-Test

This block runs a one-byte loopback self-test on a small host register interface. The host writes the self-test command, which empties the data register's full flag. The host then writes a test byte. The block copies the byte into a holding register and checks that the copy still matches the data register. It then moves the byte into an output register, where it attaches a parity bit. Bit 6 of the command selects whether that parity bit is correct or deliberately inverted.

In the next step the block checks the parity of the output copy and writes the byte back into the data register. It then compares the data register with the holding register once more. The outcome goes into a diagnostic status register as a 4-bit result code, and a completion interrupt is raised. The data register is left marked full, so the host can read the byte back.

The host can cause either compare to fail by writing the data register again while the test is running. This is how both miscompare paths are reached on a healthy datapath.

Top module: `dlb_selftest`

## Requirements
- R1: A write to address 0 whose bits 4:0 equal 5'h05 starts the test only while the block is idle. From the next cycle it clears the full flag (address 4, bit 0) and sets busy (address 4, bit 1). Other opcodes, and any command written while busy, change nothing.
- R2: When the byte is written at a clock edge, a test that has no miscompare completes at the fourth edge after it. Before that edge the interrupt stays low.
- R3: If the data register differs from the holding copy at the first compare, which falls on the second edge after the byte write, the test ends at that edge with result code 4'b0001. This happens when the host writes a different byte at the edge right after the first write.
- R4: Parity is odd over 8 bits. With command bit 6 at 0 the output copy carries correct parity and the result is 4'b0011. With bit 6 at 1 the parity is inverted and the result is 4'b0100.
- R5: A host data write at the third edge after the byte write takes priority over the internal write-back. The second compare then fails with result code 4'b0010. A host write at the second edge is overwritten by the write-back and has no effect on the result.
- R6: A compare failure takes priority over the parity result. A final miscompare under inverted parity reports 4'b0010.
- R7: The diagnostic status register at address 2 holds the result code in bits 6:3. All its other bits read as zero.
- R8: On completion the interrupt output and bit 0 of address 3 go high and the full flag is set. Busy clears. On a pass, address 1 reads back the original byte.
- R9: Reading address 3 returns the interrupt register and clears the interrupt in the following cycle.
- R10: A data write while idle only stores the byte and sets the full flag. No test runs and no interrupt follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe |
| host_addr | input | 3 | Register address |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data (combinational from address) |
| irq | output | 1 | Completion interrupt |

## Verification
The assertions assume that the host raises only one strobe per cycle and that a read and a write never share a cycle. The bench drives one strobe per task call, each lasting a single cycle, and changes inputs only at the falling edge. The assertions also assume that the parity and compare paths see stable register values within a cycle. The bench therefore times each interfering data write to land on one specific edge of the sequence, and it sweeps every byte value under both parity settings.

// File: rtl/dlb_pkg.sv
// Package: shared register map, result codes and sequencer states for the
// loopback self-test. Assumes an 8-bit or wider host data bus.
package dlb_pkg;
    localparam int ADDR_W = 3;
    localparam logic [ADDR_W-1:0] A_CMD  = 3'd0;
    localparam logic [ADDR_W-1:0] A_DATA = 3'd1;
    localparam logic [ADDR_W-1:0] A_DIAG = 3'd2;
    localparam logic [ADDR_W-1:0] A_INT  = 3'd3;
    localparam logic [ADDR_W-1:0] A_AUX  = 3'd4;

    localparam int OPC_W   = 5;
    localparam int BAD_BIT = 6;

    localparam int CODE_W   = 4;
    localparam int CODE_LSB = 3;
    localparam logic [CODE_W-1:0] RC_MISS_FIRST = 4'd1;
    localparam logic [CODE_W-1:0] RC_MISS_LAST  = 4'd2;
    localparam logic [CODE_W-1:0] RC_PAR_GOOD   = 4'd3;
    localparam logic [CODE_W-1:0] RC_PAR_BAD    = 4'd4;

    typedef enum logic [2:0] {
        ST_IDLE, ST_WAIT, ST_COPY, ST_CMP1, ST_RET, ST_CMP2
    } seq_state_e;
endpackage

// File: rtl/dlb_parity.sv
// Module: parity generator and checker over a DATA_W word.
// Produces the parity bit for the chosen sense (odd or even), optionally
// inverted, and checks a word/parity pair against that sense.
// Assumes purely combinational use; no state.
module dlb_parity #(
    parameter int DATA_W     = 8,
    parameter bit ODD_PARITY = 1'b1
) (
    input  logic [DATA_W-1:0] gen_data,
    input  logic              gen_invert,
    output logic              gen_par,
    input  logic [DATA_W-1:0] chk_data,
    input  logic              chk_par,
    output logic              chk_ok
);
    logic raw_gen;
    logic raw_chk;

    generate
        if (ODD_PARITY) begin : g_odd
            // odd sense: total ones including parity bit is odd
            always_comb raw_gen = ~(^gen_data);
            always_comb raw_chk = (^{chk_data, chk_par}) == 1'b1;
        end else begin : g_even
            // even sense: total ones including parity bit is even
            always_comb raw_gen = ^gen_data;
            always_comb raw_chk = (^{chk_data, chk_par}) == 1'b0;
        end
    endgenerate

    // apply deliberate corruption to the generated bit
    always_comb gen_par = raw_gen ^ gen_invert;
    always_comb chk_ok  = raw_chk;
endmodule

// File: rtl/dlb_datapath.sv
// Module: loopback datapath. Holds the data register, the holding copy and
// the output copy with its parity bit, and reports the data/hold compare and
// the latched parity check. Host writes to the data register win over the
// internal write-back. Assumes control strobes come from dlb_seq.
module dlb_datapath #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_data_wr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              cap_hold,
    input  logic              load_out,
    input  logic              ret_en,
    input  logic              bad_par,
    output logic [DATA_W-1:0] data_q,
    output logic              match,
    output logic              par_ok_q
);
    logic [DATA_W-1:0] hold_q;
    logic [DATA_W-1:0] out_q;
    logic              out_par_q;
    logic              gen_par;
    logic              chk_ok;

    dlb_parity #(.DATA_W(DATA_W), .ODD_PARITY(1'b1)) u_par (
        .gen_data   (hold_q),
        .gen_invert (bad_par),
        .gen_par    (gen_par),
        .chk_data   (out_q),
        .chk_par    (out_par_q),
        .chk_ok     (chk_ok)
    );

    // data register: host write first, else write-back from output copy
    always_ff @(posedge clk) begin
        if (!rst_n)            data_q <= '0;
        else if (host_data_wr) data_q <= host_wdata;
        else if (ret_en)       data_q <= out_q;
    end

    // holding copy of the data register
    always_ff @(posedge clk) begin
        if (!rst_n)        hold_q <= '0;
        else if (cap_hold) hold_q <= data_q;
    end

    // output copy with attached parity bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q     <= '0;
            out_par_q <= 1'b0;
        end else if (load_out) begin
            out_q     <= hold_q;
            out_par_q <= gen_par;
        end
    end

    // parity check result captured during write-back
    always_ff @(posedge clk) begin
        if (!rst_n)      par_ok_q <= 1'b0;
        else if (ret_en) par_ok_q <= chk_ok;
    end

    // compare of data register and holding copy
    always_comb match = (data_q == hold_q);

    // R8: without host interference the write-back returns the output copy
    assert_writeback_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_en && !host_data_wr) |=> (data_q == $past(out_q)));
endmodule

// File: rtl/dlb_seq.sv
// Module: self-test sequencer. Steps wait-for-byte, copy, first compare,
// output/parity, write-back with parity check, final compare, and reports a
// one-cycle done with the result code. Assumes start is only asserted idle.
module dlb_seq
    import dlb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              bad_in,
    input  logic              data_wr,
    input  logic              match,
    input  logic              par_ok,
    output logic              cap_hold,
    output logic              load_out,
    output logic              ret_en,
    output logic              bad_par,
    output logic              busy,
    output logic              done,
    output logic [CODE_W-1:0] code
);
    seq_state_e state_q;
    seq_state_e state_d;

    // next-state selection
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: if (start)   state_d = ST_WAIT;
            ST_WAIT: if (data_wr) state_d = ST_COPY;
            ST_COPY: state_d = ST_CMP1;
            ST_CMP1: state_d = match ? ST_RET : ST_IDLE;
            ST_RET:  state_d = ST_CMP2;
            ST_CMP2: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // parity-corruption mode latched at command acceptance
    always_ff @(posedge clk) begin
        if (!rst_n)     bad_par <= 1'b0;
        else if (start) bad_par <= bad_in;
    end

    // per-state control strobes
    always_comb begin
        cap_hold = (state_q == ST_COPY);
        load_out = (state_q == ST_CMP1) && match;
        ret_en   = (state_q == ST_RET);
        busy     = (state_q != ST_IDLE);
    end

    // completion and result code; compare failure outranks parity
    always_comb begin
        done = 1'b0;
        code = '0;
        if (state_q == ST_CMP1 && !match) begin
            done = 1'b1;
            code = RC_MISS_FIRST;
        end else if (state_q == ST_CMP2) begin
            done = 1'b1;
            if (!match)      code = RC_MISS_LAST;
            else if (par_ok) code = RC_PAR_GOOD;
            else             code = RC_PAR_BAD;
        end
    end

    // R4: every completion reports one of the four defined codes
    assert_code_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (code >= RC_MISS_FIRST && code <= RC_PAR_BAD));

    // R2: a byte written while waiting always leads into the copy step
    assert_byte_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && data_wr) |=> (state_q == ST_COPY));
endmodule

// File: rtl/dlb_selftest.sv
// Module: top of the loopback self-test. Decodes host register accesses,
// keeps the full flag, interrupt flag and diagnostic status, and connects
// the sequencer to the datapath. Assumes at most one strobe per cycle.
module dlb_selftest
    import dlb_pkg::*;
#(
    parameter int              DATA_W      = 8,
    parameter logic [OPC_W-1:0] DIAG_OPCODE = 5'h05
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              irq
);
    localparam int CODE_MSB = CODE_LSB + CODE_W - 1;

    logic              cmd_hit;
    logic              data_wr;
    logic              int_rd;
    logic              full_q;
    logic              irq_q;
    logic [DATA_W-1:0] diag_q;
    logic [DATA_W-1:0] data_q;
    logic              cap_hold, load_out, ret_en, bad_par;
    logic              busy, done, match, par_ok;
    logic [CODE_W-1:0] code;

    // host access decode
    always_comb begin
        cmd_hit = host_wr && (host_addr == A_CMD) &&
                  (host_wdata[OPC_W-1:0] == DIAG_OPCODE) && !busy;
        data_wr = host_wr && (host_addr == A_DATA);
        int_rd  = host_rd && (host_addr == A_INT);
    end

    dlb_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (cmd_hit),
        .bad_in   (host_wdata[BAD_BIT]),
        .data_wr  (data_wr),
        .match    (match),
        .par_ok   (par_ok),
        .cap_hold (cap_hold),
        .load_out (load_out),
        .ret_en   (ret_en),
        .bad_par  (bad_par),
        .busy     (busy),
        .done     (done),
        .code     (code)
    );

    dlb_datapath #(.DATA_W(DATA_W)) u_dp (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_data_wr (data_wr),
        .host_wdata   (host_wdata),
        .cap_hold     (cap_hold),
        .load_out     (load_out),
        .ret_en       (ret_en),
        .bad_par      (bad_par),
        .data_q       (data_q),
        .match        (match),
        .par_ok_q     (par_ok)
    );

    // data-register-full flag
    always_ff @(posedge clk) begin
        if (!rst_n)                full_q <= 1'b0;
        else if (cmd_hit)          full_q <= 1'b0;
        else if (data_wr || done)  full_q <= 1'b1;
    end

    // completion interrupt: set on done, cleared by reading it
    always_ff @(posedge clk) begin
        if (!rst_n)      irq_q <= 1'b0;
        else if (done)   irq_q <= 1'b1;
        else if (int_rd) irq_q <= 1'b0;
    end

    // diagnostic status: result code placed in its field, rest zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            diag_q <= '0;
        end else if (done) begin
            diag_q                    <= '0;
            diag_q[CODE_MSB:CODE_LSB] <= code;
        end
    end

    // register read multiplexer
    always_comb begin
        host_rdata = '0;
        case (host_addr)
            A_DATA: host_rdata = data_q;
            A_DIAG: host_rdata = diag_q;
            A_INT:  host_rdata[0] = irq_q;
            A_AUX:  host_rdata[1:0] = {busy, full_q};
            default: host_rdata = '0;
        endcase
    end

    always_comb irq = irq_q;

    // R1: an accepted command empties the data register
    assert_cmd_clears_full_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_hit |=> (!full_q && busy));

    // R8: completion leaves the register full and the interrupt raised
    assert_done_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (full_q && irq_q && !busy));

    // R9: reading the interrupt register clears it
    assert_int_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (int_rd && !done) |=> !irq_q);

    // R10: no interrupt rises while idle without a running test
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !irq_q) |=> !irq_q);
endmodule

// File: tb/dlb_selftest_tb.sv
module dlb_selftest_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       host_wr, host_rd;
    logic [2:0] host_addr;
    logic [7:0] host_wdata;
    logic [7:0] host_rdata;
    logic       irq;
    int         n_checks = 0;
    int         n_fails  = 0;
    bit         finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dlb_selftest u_dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        host_rd = 1'b1; host_addr = a;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic expect_reg(input logic [2:0] a, input logic [7:0] e, input string req);
        logic [7:0] v;
        rd(a, v);
        check(v == e, req, v, e);
    endtask

    // full normal run; expected code derived from parity mode
    task automatic run_pass(input logic [7:0] b, input bit bad);
        logic [7:0] exp_code;
        exp_code = bad ? 8'd4 : 8'd3;
        wr(3'd0, bad ? 8'h45 : 8'h05);
        expect_reg(3'd4, 8'h02, "R1");
        wr(3'd1, b);
        repeat (3) @(negedge clk);
        check(irq == 1'b0, "R2", irq, 0);
        @(negedge clk);
        check(irq == 1'b1, "R2", irq, 1);
        expect_reg(3'd2, exp_code << 3, bad ? "R4 R7 bad" : "R4 R7 good");
        expect_reg(3'd1, b, "R8");
        expect_reg(3'd4, 8'h01, "R8");
        expect_reg(3'd3, 8'h01, "R9");
        check(irq == 1'b0, "R9", irq, 0);
    endtask

    initial begin
        logic [7:0] v;
        rst_n = 1'b0; host_wr = 1'b0; host_rd = 1'b0;
        host_addr = '0; host_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        check(irq == 1'b0, "R8 reset irq", irq, 0);
        expect_reg(3'd4, 8'h00, "R1 reset aux");
        expect_reg(3'd2, 8'h00, "R7 reset diag");

        // R10: idle data write only stores
        wr(3'd1, 8'h5A);
        repeat (6) @(negedge clk);
        check(irq == 1'b0, "R10", irq, 0);
        expect_reg(3'd4, 8'h01, "R10");
        expect_reg(3'd1, 8'h5A, "R10");

        // R1: wrong opcode ignored
        wr(3'd0, 8'h06);
        expect_reg(3'd4, 8'h01, "R1 bad opcode");

        // R1: command while busy ignored (bad-parity request must not take)
        wr(3'd0, 8'h05);
        wr(3'd0, 8'h45);
        wr(3'd1, 8'h33);
        repeat (4) @(negedge clk);
        expect_reg(3'd2, 8'd3 << 3, "R1 busy cmd");
        expect_reg(3'd3, 8'h01, "R9");

        // sweep all bytes, both parity modes
        for (int m = 0; m < 2; m++)
            for (int b = 0; b < 256; b++)
                run_pass(8'(b), m[0]);

        // R3: initial miscompare
        wr(3'd0, 8'h05);
        wr(3'd1, 8'hA5);
        wr(3'd1, 8'h3C);
        @(negedge clk);
        check(irq == 1'b1, "R3", irq, 1);
        expect_reg(3'd2, 8'd1 << 3, "R3");
        expect_reg(3'd1, 8'h3C, "R3");
        expect_reg(3'd3, 8'h01, "R9");

        // R5: final miscompare
        wr(3'd0, 8'h05);
        wr(3'd1, 8'h96);
        repeat (2) @(negedge clk);
        wr(3'd1, 8'h69);
        @(negedge clk);
        check(irq == 1'b1, "R5", irq, 1);
        expect_reg(3'd2, 8'd2 << 3, "R5");
        expect_reg(3'd1, 8'h69, "R5");
        expect_reg(3'd3, 8'h01, "R9");

        // R5: write at second edge is overwritten, no effect
        wr(3'd0, 8'h05);
        wr(3'd1, 8'hC3);
        @(negedge clk);
        wr(3'd1, 8'h11);
        repeat (2) @(negedge clk);
        check(irq == 1'b1, "R5 no effect", irq, 1);
        expect_reg(3'd2, 8'd3 << 3, "R5 no effect");
        expect_reg(3'd1, 8'hC3, "R5 no effect");
        expect_reg(3'd3, 8'h01, "R9");

        // R6: compare failure outranks bad parity
        wr(3'd0, 8'h45);
        wr(3'd1, 8'h0F);
        repeat (2) @(negedge clk);
        wr(3'd1, 8'hF0);
        @(negedge clk);
        expect_reg(3'd2, 8'd2 << 3, "R6");
        expect_reg(3'd3, 8'h01, "R9");

        // R6: initial miscompare under bad parity
        wr(3'd0, 8'h45);
        wr(3'd1, 8'h01);
        wr(3'd1, 8'h02);
        @(negedge clk);
        expect_reg(3'd2, 8'd1 << 3, "R6 first");
        rd(3'd3, v);
        check(v == 8'h01, "R9", v, 1);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end
endmodule